// File: doc/BRIEF.md
# Indexed Display Register Port

This block is the register front end of a display controller. Software reaches it through a narrow window of 32-bit I/O ports. It first writes a register number to the index port. It then reads or writes that register through the value port. The block holds the mode, enable, configuration and cursor state, a guest identifier, a synchronisation flag and a small scratch array. It also answers reads of fixed identity, limit and capability values.

Each register applies its own acceptance rule to writes. An oversized width or height is dropped. The identity register accepts only the known version codes. A pixel format other than 32 bits per pixel withdraws the configuration. The cursor-visibility register tolerates codes that neither show nor hide.

The block drives the current settings straight to a display pipeline. It also emits two one-cycle pulses. One asks for a full redraw (invalidate). The other starts a command run (sync start).

Top module: `idxval_regport`

## Requirements
- R1: After reset the index is 0, enable, config-done, cursor visibility and busy are 0, and the identity register (index 0) reads 0x90000002.
- R2: A write to port offset 0 latches the 32-bit index. A read of offset 0 returns the index. Every read returns its data with `rvalid_o` high in the cycle after the access, and a write never raises `rvalid_o`.
- R3: A write to index 0 is accepted only for 0x90000000, 0x90000001 or 0x90000002. Any other value leaves the identity unchanged.
- R4: Writes to width (index 2) above MAX_W (default 2368) and to height (index 3) above MAX_H (default 1770) are ignored. An accepted width or height write pulses `inval_o` in the next cycle.
- R5: Writing bits per pixel (index 7) with a value other than 32 clears config-done and pulses `inval_o`. Writing 32 changes nothing. Indices 7 and 28 read the pixel depth, which is 32 by default.
- R6: The depth register (index 6) reads 24 when the pixel depth is 32, and reads the pixel depth otherwise. Writes to it are ignored.
- R7: Writing index 27 with 1 makes the cursor visible and with 0 hides it. Any other value, such as 2 or 3, leaves visibility unchanged.
- R8: Writing index 21 sets busy and pulses `sync_start_o` once. Busy stays set until `run_done_i` is seen, with the sync write taking priority. Indices 21 and 22 both read busy.
- R9: The scratch array occupies indices 1792 to 1792+SCR_DEPTH-1 (default 16 words). It stores and returns full words, and index 29 reads SCR_DEPTH.
- R10: Palette indices 1024 to 1791 read as zero, ignore writes and raise no error.
- R11: Reading port offset 2 returns 0x0000CAFE and writes to it are ignored. Offsets 3 and above read 0xFFFFFFFF.
- R12: A value-port access to an index outside the defined set reads zero, changes no state, and pulses `err_o` in the next cycle. Indices 8 to 16 and 18 to 19 are outside the set, and so is anything above the scratch array.
- R13: Enable (1), config-done (20), guest id (23) and cursor id/x/y (24 to 26) store what is written and drive their outputs; a nonzero write to enable or config-done gives 1, and an enable write also pulses `inval_o`. Max width (4), max height (5) and capabilities (17, default 0x000000E3) are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_i | input | 1 | Port access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| off_i | input | OFF_W (4) | Port offset: 0 index, 1 value, 2 dummy |
| wdata_i | input | 32 | Write data |
| run_done_i | input | 1 | Command run finished, clears busy |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid |
| err_o | output | 1 | Undefined-index access pulse |
| disp_en_o | output | 1 | Display enable |
| cfg_done_o | output | 1 | Configuration complete |
| width_o | output | DIM_W (12) | Mode width |
| height_o | output | DIM_W (12) | Mode height |
| guest_id_o | output | 32 | Guest identifier |
| cur_id_o | output | 32 | Cursor id |
| cur_x_o | output | 32 | Cursor x |
| cur_y_o | output | 32 | Cursor y |
| cur_vis_o | output | 1 | Cursor visible |
| busy_o | output | 1 | Sync in progress |
| inval_o | output | 1 | Full-redraw request pulse |
| sync_start_o | output | 1 | Command-run start pulse |

## Verification
The assertions assume that an access lasts exactly one cycle and that its offset, direction and data are stable while `acc_i` is high. They also assume that `run_done_i` only follows a sync write. The bench drives every access from a task that holds the strobe for a single cycle and then leaves an idle cycle. It raises `run_done_i` on its own only after a sync write is pending. A behavioural model in the bench follows the register rules and compares every output on every clock, so the one-cycle pulses are checked for both presence and width.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int unsigned IX_ID     = 0;
  localparam int unsigned IX_EN     = 1;
  localparam int unsigned IX_W      = 2;
  localparam int unsigned IX_H      = 3;
  localparam int unsigned IX_MAXW   = 4;
  localparam int unsigned IX_MAXH   = 5;
  localparam int unsigned IX_DEPTH  = 6;
  localparam int unsigned IX_BPP    = 7;
  localparam int unsigned IX_CAPS   = 17;
  localparam int unsigned IX_CFG    = 20;
  localparam int unsigned IX_SYNC   = 21;
  localparam int unsigned IX_BUSY   = 22;
  localparam int unsigned IX_GUEST  = 23;
  localparam int unsigned IX_CUR_ID = 24;
  localparam int unsigned IX_CUR_X  = 25;
  localparam int unsigned IX_CUR_Y  = 26;
  localparam int unsigned IX_CUR_ON = 27;
  localparam int unsigned IX_HBPP   = 28;
  localparam int unsigned IX_SCR_SZ = 29;
  localparam int unsigned IX_Z_LO   = 30;
  localparam int unsigned IX_Z_HI   = 32;
  localparam int unsigned PAL_BASE  = 1024;
  localparam int unsigned PAL_LAST  = PAL_BASE + 767;
  localparam int unsigned SCR_BASE  = PAL_BASE + 768;

  localparam logic [31:0] ID_V0    = 32'h9000_0000;
  localparam logic [31:0] ID_V1    = 32'h9000_0001;
  localparam logic [31:0] ID_V2    = 32'h9000_0002;
  localparam logic [31:0] DUMMY_RD = 32'h0000_CAFE;

  typedef enum logic [1:0] {OFF_INDEX, OFF_VALUE, OFF_DUMMY, OFF_NONE} off_e;
endpackage

// File: rtl/regport_scratch.sv
module regport_scratch #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [31:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_i && waddr_i == AW'(i)) q <= wdata_i;
    end
    assign ent[i] = q;
  end

  assign rdata_o = ent[raddr_i];
endmodule

// File: rtl/regport_ctrl.sv
module regport_ctrl
  import regport_pkg::*;
#(
  parameter int unsigned DIM_W = 12,
  parameter int unsigned MAX_W = 2368,
  parameter int unsigned MAX_H = 1770,
  parameter int unsigned DEF_W = 1024,
  parameter int unsigned DEF_H = 768
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [31:0]      idx_i,
  input  logic [31:0]      wdata_i,
  input  logic             run_done_i,
  output logic [31:0]      id_o,
  output logic             en_o,
  output logic             cfg_o,
  output logic [DIM_W-1:0] width_o,
  output logic [DIM_W-1:0] height_o,
  output logic [31:0]      guest_o,
  output logic [31:0]      cur_id_o,
  output logic [31:0]      cur_x_o,
  output logic [31:0]      cur_y_o,
  output logic             cur_vis_o,
  output logic             busy_o,
  output logic             inv_o,
  output logic             sync_o
);
  logic sel_id, sel_en, sel_w, sel_h, sel_bpp, sel_cfg, sel_sync;
  logic sel_guest, sel_cid, sel_cx, sel_cy, sel_con;
  logic w_ok, h_ok, id_ok, bpp_bad, inv_d;

  assign sel_id    = wr_i && idx_i == 32'(IX_ID);
  assign sel_en    = wr_i && idx_i == 32'(IX_EN);
  assign sel_w     = wr_i && idx_i == 32'(IX_W);
  assign sel_h     = wr_i && idx_i == 32'(IX_H);
  assign sel_bpp   = wr_i && idx_i == 32'(IX_BPP);
  assign sel_cfg   = wr_i && idx_i == 32'(IX_CFG);
  assign sel_sync  = wr_i && idx_i == 32'(IX_SYNC);
  assign sel_guest = wr_i && idx_i == 32'(IX_GUEST);
  assign sel_cid   = wr_i && idx_i == 32'(IX_CUR_ID);
  assign sel_cx    = wr_i && idx_i == 32'(IX_CUR_X);
  assign sel_cy    = wr_i && idx_i == 32'(IX_CUR_Y);
  assign sel_con   = wr_i && idx_i == 32'(IX_CUR_ON);

  assign w_ok    = wdata_i <= 32'(MAX_W);
  assign h_ok    = wdata_i <= 32'(MAX_H);
  assign id_ok   = wdata_i == ID_V0 || wdata_i == ID_V1 || wdata_i == ID_V2;
  assign bpp_bad = wdata_i != 32'd32;
  assign inv_d   = sel_en || (sel_w && w_ok) || (sel_h && h_ok) || (sel_bpp && bpp_bad);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_o      <= ID_V2;
      en_o      <= 1'b0;
      cfg_o     <= 1'b0;
      width_o   <= DIM_W'(DEF_W);
      height_o  <= DIM_W'(DEF_H);
      guest_o   <= '0;
      cur_id_o  <= '0;
      cur_x_o   <= '0;
      cur_y_o   <= '0;
      cur_vis_o <= 1'b0;
      busy_o    <= 1'b0;
      inv_o     <= 1'b0;
      sync_o    <= 1'b0;
    end else begin
      inv_o  <= inv_d;
      sync_o <= sel_sync;
      if (sel_id && id_ok) id_o <= wdata_i;
      if (sel_en) en_o <= |wdata_i;
      if (sel_w && w_ok) width_o <= wdata_i[DIM_W-1:0];
      if (sel_h && h_ok) height_o <= wdata_i[DIM_W-1:0];
      if (sel_cfg) cfg_o <= |wdata_i;
      else if (sel_bpp && bpp_bad) cfg_o <= 1'b0;
      if (sel_guest) guest_o <= wdata_i;
      if (sel_cid) cur_id_o <= wdata_i;
      if (sel_cx) cur_x_o <= wdata_i;
      if (sel_cy) cur_y_o <= wdata_i;
      // only show/hide codes move visibility
      if (sel_con && wdata_i == 32'd1) cur_vis_o <= 1'b1;
      else if (sel_con && wdata_i == 32'd0) cur_vis_o <= 1'b0;
      if (sel_sync) busy_o <= 1'b1;
      else if (run_done_i) busy_o <= 1'b0;
    end
  end

  a_r8_busy_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == 32'(IX_SYNC)) |=> (busy_o && sync_o));
  a_r7_cursor_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == 32'(IX_CUR_ON) && wdata_i > 32'd1) |=> $stable(cur_vis_o));
  a_r5_bpp_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == 32'(IX_BPP) && wdata_i != 32'd32) |=> (!cfg_o && inv_o));
  a_r4_dim_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(width_o) <= 32'(MAX_W)) && (32'(height_o) <= 32'(MAX_H)));
  a_r3_id_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_o == ID_V0 || id_o == ID_V1 || id_o == ID_V2));
endmodule

// File: rtl/regport_rdmux.sv
module regport_rdmux
  import regport_pkg::*;
#(
  parameter int unsigned DIM_W     = 12,
  parameter int unsigned MAX_W     = 2368,
  parameter int unsigned MAX_H     = 1770,
  parameter int unsigned PIX_DEPTH = 32,
  parameter int unsigned SCR_DEPTH = 16,
  parameter logic [31:0] CAPS      = 32'h0000_00E3
) (
  input  logic [31:0]      idx_i,
  input  logic             scr_hit_i,
  input  logic [31:0]      scr_data_i,
  input  logic [31:0]      id_i,
  input  logic             en_i,
  input  logic             cfg_i,
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  input  logic [31:0]      guest_i,
  input  logic [31:0]      cur_id_i,
  input  logic [31:0]      cur_x_i,
  input  logic [31:0]      cur_y_i,
  input  logic             cur_vis_i,
  input  logic             busy_i,
  output logic [31:0]      val_o,
  output logic             known_o
);
  localparam logic [31:0] DEPTH_RD = (PIX_DEPTH == 32) ? 32'd24 : 32'(PIX_DEPTH);

  always_comb begin
    val_o   = '0;
    known_o = 1'b1;
    if (scr_hit_i) val_o = scr_data_i;
    else if (idx_i >= 32'(PAL_BASE) && idx_i <= 32'(PAL_LAST)) val_o = '0;
    else if (idx_i >= 32'(IX_Z_LO) && idx_i <= 32'(IX_Z_HI)) val_o = '0;
    else begin
      case (idx_i)
        32'(IX_ID):     val_o = id_i;
        32'(IX_EN):     val_o = {31'd0, en_i};
        32'(IX_W):      val_o = 32'(width_i);
        32'(IX_H):      val_o = 32'(height_i);
        32'(IX_MAXW):   val_o = 32'(MAX_W);
        32'(IX_MAXH):   val_o = 32'(MAX_H);
        32'(IX_DEPTH):  val_o = DEPTH_RD;
        32'(IX_BPP),
        32'(IX_HBPP):   val_o = 32'(PIX_DEPTH);
        32'(IX_CAPS):   val_o = CAPS;
        32'(IX_CFG):    val_o = {31'd0, cfg_i};
        32'(IX_SYNC),
        32'(IX_BUSY):   val_o = {31'd0, busy_i};
        32'(IX_GUEST):  val_o = guest_i;
        32'(IX_CUR_ID): val_o = cur_id_i;
        32'(IX_CUR_X):  val_o = cur_x_i;
        32'(IX_CUR_Y):  val_o = cur_y_i;
        32'(IX_CUR_ON): val_o = {31'd0, cur_vis_i};
        32'(IX_SCR_SZ): val_o = 32'(SCR_DEPTH);
        default:        known_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/idxval_regport.sv
module idxval_regport
  import regport_pkg::*;
#(
  parameter int unsigned OFF_W     = 4,
  parameter int unsigned DIM_W     = 12,
  parameter int unsigned MAX_W     = 2368,
  parameter int unsigned MAX_H     = 1770,
  parameter int unsigned DEF_W     = 1024,
  parameter int unsigned DEF_H     = 768,
  parameter int unsigned PIX_DEPTH = 32,
  parameter int unsigned SCR_DEPTH = 16,
  parameter logic [31:0] CAPS      = 32'h0000_00E3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             we_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [31:0]      wdata_i,
  input  logic             run_done_i,
  output logic [31:0]      rdata_o,
  output logic             rvalid_o,
  output logic             err_o,
  output logic             disp_en_o,
  output logic             cfg_done_o,
  output logic [DIM_W-1:0] width_o,
  output logic [DIM_W-1:0] height_o,
  output logic [31:0]      guest_id_o,
  output logic [31:0]      cur_id_o,
  output logic [31:0]      cur_x_o,
  output logic [31:0]      cur_y_o,
  output logic             cur_vis_o,
  output logic             busy_o,
  output logic             inval_o,
  output logic             sync_start_o
);
  localparam int unsigned SCR_AW = $clog2(SCR_DEPTH);

  off_e        off_kind;
  logic [31:0] idx_q, id_w, scr_rd, val_rd, scr_off;
  logic        known, scr_hit, val_wr;

  always_comb begin
    case (off_i)
      OFF_W'(0): off_kind = OFF_INDEX;
      OFF_W'(1): off_kind = OFF_VALUE;
      OFF_W'(2): off_kind = OFF_DUMMY;
      default:   off_kind = OFF_NONE;
    endcase
  end

  assign val_wr  = acc_i && we_i && off_kind == OFF_VALUE;
  assign scr_off = idx_q - 32'(SCR_BASE);
  assign scr_hit = idx_q >= 32'(SCR_BASE) && scr_off < 32'(SCR_DEPTH);

  regport_ctrl #(
    .DIM_W(DIM_W), .MAX_W(MAX_W), .MAX_H(MAX_H), .DEF_W(DEF_W), .DEF_H(DEF_H)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .wr_i(val_wr), .idx_i(idx_q), .wdata_i, .run_done_i,
    .id_o(id_w), .en_o(disp_en_o), .cfg_o(cfg_done_o),
    .width_o, .height_o, .guest_o(guest_id_o),
    .cur_id_o, .cur_x_o, .cur_y_o, .cur_vis_o,
    .busy_o, .inv_o(inval_o), .sync_o(sync_start_o)
  );

  regport_scratch #(.DEPTH(SCR_DEPTH)) u_scr (
    .clk_i, .rst_ni,
    .wr_i(val_wr && scr_hit), .waddr_i(scr_off[SCR_AW-1:0]), .wdata_i,
    .raddr_i(scr_off[SCR_AW-1:0]), .rdata_o(scr_rd)
  );

  regport_rdmux #(
    .DIM_W(DIM_W), .MAX_W(MAX_W), .MAX_H(MAX_H), .PIX_DEPTH(PIX_DEPTH),
    .SCR_DEPTH(SCR_DEPTH), .CAPS(CAPS)
  ) u_mux (
    .idx_i(idx_q), .scr_hit_i(scr_hit), .scr_data_i(scr_rd),
    .id_i(id_w), .en_i(disp_en_o), .cfg_i(cfg_done_o),
    .width_i(width_o), .height_i(height_o), .guest_i(guest_id_o),
    .cur_id_i(cur_id_o), .cur_x_i(cur_x_o), .cur_y_i(cur_y_o),
    .cur_vis_i(cur_vis_o), .busy_i(busy_o),
    .val_o(val_rd), .known_o(known)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      rvalid_o <= acc_i && !we_i;
      err_o    <= acc_i && off_kind == OFF_VALUE && !known;
      if (acc_i && we_i && off_kind == OFF_INDEX) idx_q <= wdata_i;
      if (acc_i && !we_i) begin
        case (off_kind)
          OFF_INDEX: rdata_o <= idx_q;
          OFF_VALUE: rdata_o <= val_rd;
          OFF_DUMMY: rdata_o <= DUMMY_RD;
          default:   rdata_o <= '1;
        endcase
      end
    end
  end

  a_r2_rd_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !we_i) |=> rvalid_o);
  a_r2_wr_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && we_i) |=> !rvalid_o);
  a_r10_palette_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && off_i == OFF_W'(1) && idx_q >= 32'(PAL_BASE) && idx_q <= 32'(PAL_LAST))
    |=> !err_o);
  a_r11_dummy_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !we_i && off_i == OFF_W'(2)) |=> (rdata_o == DUMMY_RD));
endmodule

// File: tb/sim_idxval_regport.sv
`timescale 1ns/1ps
module sim_idxval_regport;
  logic clk = 1'b0, rst_n = 1'b0;
  logic acc = 1'b0, we = 1'b0, run_done = 1'b0;
  logic [3:0] off = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, guest_id, cur_id, cur_x, cur_y;
  logic rvalid, err, disp_en, cfg_done, cur_vis, busy, inval, sync_start;
  logic [11:0] width, height;

  always #4 clk = ~clk;

  idxval_regport u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .we_i(we), .off_i(off),
    .wdata_i(wdata), .run_done_i(run_done), .rdata_o(rdata), .rvalid_o(rvalid),
    .err_o(err), .disp_en_o(disp_en), .cfg_done_o(cfg_done), .width_o(width),
    .height_o(height), .guest_id_o(guest_id), .cur_id_o(cur_id), .cur_x_o(cur_x),
    .cur_y_o(cur_y), .cur_vis_o(cur_vis), .busy_o(busy), .inval_o(inval),
    .sync_start_o(sync_start)
  );

  int checks = 0, errors = 0;
  string cur_tag = "R1";

  // reference model state
  logic [31:0] m_idx, m_id, m_guest, m_cid, m_cx, m_cy, m_w, m_h, e_rd;
  logic m_en, m_cfg, m_vis, m_busy, e_rv, e_err, e_inv, e_sync;
  logic [31:0] m_scr [int unsigned];
  logic s_acc, s_we, s_rd;
  logic [3:0] s_off;
  logic [31:0] s_d;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit m_known(input logic [31:0] ix);
    return (ix <= 7) || ix == 17 || (ix >= 20 && ix <= 32) || (ix >= 1024 && ix < 1808);
  endfunction

  function automatic logic [31:0] m_read(input logic [31:0] ix);
    if (ix >= 1792 && ix < 1808) return m_scr.exists(ix) ? m_scr[ix] : 32'd0;
    case (ix)
      0: return m_id;
      1: return {31'd0, m_en};
      2: return m_w;
      3: return m_h;
      4: return 32'd2368;
      5: return 32'd1770;
      6: return 32'd24;
      7, 28: return 32'd32;
      17: return 32'h0000_00E3;
      20: return {31'd0, m_cfg};
      21, 22: return {31'd0, m_busy};
      23: return m_guest;
      24: return m_cid;
      25: return m_cx;
      26: return m_cy;
      27: return {31'd0, m_vis};
      29: return 32'd16;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    s_acc = acc; s_we = we; s_off = off; s_d = wdata; s_rd = run_done;
    #1;
    if (!rst_n) begin
      m_idx = 0; m_id = 32'h9000_0002; m_en = 0; m_cfg = 0; m_vis = 0; m_busy = 0;
      m_w = 1024; m_h = 768; m_guest = 0; m_cid = 0; m_cx = 0; m_cy = 0;
      e_rv = 0; e_err = 0; e_inv = 0; e_sync = 0; e_rd = 0;
      m_scr.delete();
    end else begin
      e_rv = 0; e_err = 0; e_inv = 0; e_sync = 0;
      if (s_acc && !s_we) begin
        e_rv = 1;
        case (s_off)
          0: e_rd = m_idx;
          1: e_rd = m_read(m_idx);
          2: e_rd = 32'h0000_CAFE;
          default: e_rd = 32'hFFFF_FFFF;
        endcase
      end
      if (s_acc && s_off == 1 && !m_known(m_idx)) e_err = 1;
      if (s_acc && s_we && s_off == 0) m_idx = s_d;
      else if (s_acc && s_we && s_off == 1) begin
        if (m_idx >= 1792 && m_idx < 1808) m_scr[m_idx] = s_d;
        case (m_idx)
          0: if (s_d == 32'h9000_0000 || s_d == 32'h9000_0001 || s_d == 32'h9000_0002) m_id = s_d;
          1: begin m_en = (s_d != 0); e_inv = 1; end
          2: if (s_d <= 2368) begin m_w = s_d; e_inv = 1; end
          3: if (s_d <= 1770) begin m_h = s_d; e_inv = 1; end
          7: if (s_d != 32) begin m_cfg = 0; e_inv = 1; end
          20: m_cfg = (s_d != 0);
          21: begin m_busy = 1; e_sync = 1; end
          23: m_guest = s_d;
          24: m_cid = s_d;
          25: m_cx = s_d;
          26: m_cy = s_d;
          27: if (s_d == 1) m_vis = 1; else if (s_d == 0) m_vis = 0;
          default: ;
        endcase
      end
      if (s_rd && !(s_acc && s_we && s_off == 1 && m_idx == 21)) m_busy = 0;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk({cur_tag, " rvalid"}, {31'd0, rvalid}, {31'd0, e_rv});
    if (e_rv) chk({cur_tag, " rdata"}, rdata, e_rd);
    chk("R12 err", {31'd0, err}, {31'd0, e_err});
    chk("R13 enable", {31'd0, disp_en}, {31'd0, m_en});
    chk("R5 cfg_done", {31'd0, cfg_done}, {31'd0, m_cfg});
    chk("R4 width", {20'd0, width}, m_w);
    chk("R4 height", {20'd0, height}, m_h);
    chk("R4 inval", {31'd0, inval}, {31'd0, e_inv});
    chk("R13 guest", guest_id, m_guest);
    chk("R13 cursor id", cur_id, m_cid);
    chk("R13 cursor x", cur_x, m_cx);
    chk("R13 cursor y", cur_y, m_cy);
    chk("R7 visible", {31'd0, cur_vis}, {31'd0, m_vis});
    chk("R8 busy", {31'd0, busy}, {31'd0, m_busy});
    chk("R8 sync_start", {31'd0, sync_start}, {31'd0, e_sync});
  end

  task automatic io(input bit w, input int o, input logic [31:0] d);
    @(negedge clk);
    acc = 1'b1; we = w; off = 4'(o); wdata = d;
    @(negedge clk);
    acc = 1'b0; we = 1'b0;
  endtask

  task automatic wreg(input int ix, input logic [31:0] d);
    io(1, 0, ix); io(1, 1, d);
  endtask

  task automatic rreg(input int ix);
    io(1, 0, ix); io(0, 1, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    cur_tag = "R1"; io(0, 0, 0); rreg(0); rreg(1); rreg(20); rreg(27); rreg(22);
    // R2 index latch
    cur_tag = "R2"; io(1, 0, 32'h0000_0005); io(0, 0, 0);
    io(1, 0, 32'hDEAD_BEEF); io(0, 0, 0);
    // R3 identity codes
    cur_tag = "R3"; wreg(0, 32'h9000_0001); rreg(0);
    wreg(0, 32'h1234_5678); rreg(0); wreg(0, 32'h9000_0003); rreg(0);
    wreg(0, 32'h9000_0000); rreg(0);
    // R4 width/height limits
    cur_tag = "R4"; wreg(2, 2368); rreg(2); wreg(2, 2369); rreg(2);
    wreg(3, 1770); rreg(3); wreg(3, 1771); rreg(3); wreg(2, 800); wreg(3, 600);
    // R13 enable/config and read-only
    cur_tag = "R13"; wreg(1, 7); rreg(1); wreg(20, 1); rreg(20);
    wreg(23, 32'h0000_5007); wreg(24, 3); wreg(25, 640); wreg(26, 480);
    rreg(23); rreg(4); rreg(5); rreg(17); wreg(4, 5); rreg(4); wreg(17, 0); rreg(17);
    // R5 bits per pixel
    cur_tag = "R5"; wreg(7, 32); rreg(20); rreg(7); rreg(28); wreg(7, 16); rreg(20);
    // R6 depth
    cur_tag = "R6"; rreg(6); wreg(6, 8); rreg(6);
    // R7 cursor visibility
    cur_tag = "R7"; wreg(27, 1); wreg(27, 2); rreg(27); wreg(27, 3); wreg(27, 0);
    wreg(27, 3); rreg(27); wreg(27, 1); wreg(27, 5); rreg(27);
    // R8 sync/busy
    cur_tag = "R8"; wreg(21, 0); rreg(21); rreg(22);
    @(negedge clk); run_done = 1'b1; @(negedge clk); run_done = 1'b0;
    rreg(22); wreg(21, 1); rreg(21);
    @(negedge clk); run_done = 1'b1; @(negedge clk); run_done = 1'b0;
    // R9 scratch
    cur_tag = "R9"; rreg(29); wreg(1792, 32'hA5A5_0001); wreg(1807, 32'h5A5A_FFFF);
    rreg(1792); rreg(1807); rreg(1800);
    // R10 palette
    cur_tag = "R10"; wreg(1024, 32'h00FF_FFFF); rreg(1024); wreg(1791, 1); rreg(1791);
    // R11 dummy and unmapped offsets
    cur_tag = "R11"; io(0, 2, 0); io(1, 2, 32'h1111_1111); io(0, 2, 0);
    io(0, 3, 0); io(0, 15, 0); io(1, 3, 0); io(0, 0, 0);
    // R12 undefined indices
    cur_tag = "R12"; rreg(8); wreg(16, 9); rreg(18); rreg(1000);
    wreg(1808, 32'h7777_7777); rreg(1808); rreg(1792);
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule